// File: doc/BRIEF.md
# Embedded Message Length Extractor

This block watches the payload bytes of one receive (host-to-device) endpoint as they stream in. A single message may be spread over several packets. At a byte offset set by software, the block picks a two-byte transfer length out of the stream. The low byte comes first in the stream and the high byte follows it. Each byte is placed in its own fixed field of a 32-bit descriptor length word. Each byte also raises its own flag, and a combined done output is high once both bytes are in.

A start-of-message pulse sets the byte position back to zero and clears any earlier capture. After that pulse, every accepted byte advances the position by one. Packet boundaries do not reset the position. Capture happens only while the automatic length-extraction mode is enabled. Once both bytes are held, extraction stops, and the captured values stay fixed until the next start-of-message pulse.

Top module: `msg_len_extract`

## Requirements
- R1: After reset, `msg_len`, `desc_len_word`, `lsb_done`, `msb_done` and `done` are all zero.
- R2: The byte accepted at position `len_ofs` is captured as the low length byte. It appears on `msg_len[7:0]` and on `desc_len_word[23:16]`, and `lsb_done` goes high on the clock edge after that byte is accepted.
- R3: The byte accepted at position `len_ofs`+1 is captured as the high length byte, but only if the low byte is already held. It appears on `msg_len[15:8]` and on `desc_len_word[31:24]`, and `msb_done` rises one edge after that byte is accepted.
- R4: Positions count from 0. A byte accepted in the same cycle as `sop` is position 0, so with `len_ofs` = 0 that byte is the low length byte.
- R5: The position counter keeps counting across `pkt_end`. `pkt_end` has no effect on position or capture.
- R6: Once both bytes are held, `done` is high, and no later byte changes `msg_len`, `desc_len_word` or the flags.
- R7: `sop` clears both flags, the length and the position. The cleared state is visible on the next edge.
- R8: While `enable` is low, accepted bytes are not captured and the flags and length hold their values. The position still advances for every accepted byte.
- R9: If the message stops before both bytes are captured, `done` stays low and any partial capture (flag and byte) is held until the next `sop`.
- R10: Only cycles with `byte_vld` high advance the position, so idle gaps between bytes do not shift the capture point. `desc_len_word[15:0]` is always zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Automatic length-extraction mode select |
| sop | input | 1 | Start-of-message pulse |
| pkt_end | input | 1 | Packet boundary marker (does not affect counting) |
| byte_vld | input | 1 | Payload byte valid strobe |
| byte_data | input | 8 | Payload byte |
| len_ofs | input | OFS_W | Byte position of the length's low byte |
| msg_len | output | 16 | Captured message length |
| desc_len_word | output | 32 | Descriptor length word: high byte in [31:24], low byte in [23:16] |
| lsb_done | output | 1 | Low length byte captured |
| msb_done | output | 1 | High length byte captured |
| done | output | 1 | Both length bytes captured |

## Verification
The bench sets the offset so that the length straddles a packet boundary. A design that reset its count on `pkt_end` would then capture payload bytes from the wrong place. It drives a byte in the same cycle as `sop` with offset 0, which catches an off-by-one position or a `sop` that throws away the byte beside it. It drops `enable` exactly on the low-byte position to check that nothing is captured there and that the high byte is not taken out of order. It also feeds bytes after completion and cuts messages short, so that a design that kept overwriting the length, or lost its partial flags before the next `sop`, would show a mismatch.

// File: rtl/msglen_pkg.sv
package msglen_pkg;
  localparam int BYTE_W = 8;
  localparam int N_LANES = 2;
  typedef logic [BYTE_W-1:0] byte_t;
  typedef struct packed {
    logic  got;
    byte_t val;
  } lane_t;
endpackage

// File: rtl/msglen_pos_cnt.sv
module msglen_pos_cnt #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sop,
  input  logic             byte_vld,
  output logic [CNT_W-1:0] pos_eff
);
  localparam logic [CNT_W-1:0] POS_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    pos_eff = sop ? '0 : cnt_q;
    cnt_d   = cnt_q;
    if (byte_vld) begin
      cnt_d = (pos_eff == POS_MAX) ? pos_eff : pos_eff + 1'b1;
    end else if (sop) begin
      cnt_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/msglen_lane.sv
module msglen_lane
  import msglen_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sop,
  input  logic             take,
  input  logic             gate,
  input  logic [CNT_W-1:0] pos_eff,
  input  logic [CNT_W-1:0] target,
  input  byte_t            data,
  output lane_t            st
);
  lane_t st_q, st_d, base;

  always_comb begin
    base = sop ? '0 : st_q;
    st_d = base;
    if (take && gate && !base.got && (pos_eff == target)) begin
      st_d.got = 1'b1;
      st_d.val = data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= '0;
    else        st_q <= st_d;
  end

  assign st = st_q;
endmodule

// File: rtl/msg_len_extract.sv
module msg_len_extract
  import msglen_pkg::*;
#(
  parameter int OFS_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             sop,
  input  logic             pkt_end,
  input  logic             byte_vld,
  input  logic [7:0]       byte_data,
  input  logic [OFS_W-1:0] len_ofs,
  output logic [15:0]      msg_len,
  output logic [31:0]      desc_len_word,
  output logic             lsb_done,
  output logic             msb_done,
  output logic             done
);
  localparam int CNT_W = OFS_W + 1;

  logic [CNT_W-1:0]   pos_eff;
  logic [CNT_W-1:0]   base_tgt;
  logic               take;
  logic [N_LANES-1:0] gate;
  lane_t              lanes [N_LANES];

  // Boundary marker is accepted but counting is deliberately blind to it.
  logic unused_pkt_end;
  assign unused_pkt_end = pkt_end;

  assign take     = byte_vld & enable;
  assign base_tgt = {1'b0, len_ofs};

  msglen_pos_cnt #(.CNT_W(CNT_W)) u_pos (
    .clk      (clk),
    .rst_n    (rst_n),
    .sop      (sop),
    .byte_vld (byte_vld),
    .pos_eff  (pos_eff)
  );

  for (genvar g = 0; g < N_LANES; g++) begin : g_lane
    if (g == 0) begin : g_first
      assign gate[g] = 1'b1;
    end else begin : g_next
      assign gate[g] = lanes[g-1].got;
    end

    msglen_lane #(.CNT_W(CNT_W)) u_lane (
      .clk     (clk),
      .rst_n   (rst_n),
      .sop     (sop),
      .take    (take),
      .gate    (gate[g]),
      .pos_eff (pos_eff),
      .target  (base_tgt + CNT_W'(g)),
      .data    (byte_data),
      .st      (lanes[g])
    );
  end

  assign msg_len       = {lanes[1].val, lanes[0].val};
  assign desc_len_word = {lanes[1].val, lanes[0].val, 16'h0000};
  assign lsb_done      = lanes[0].got;
  assign msb_done      = lanes[1].got;
  assign done          = lanes[0].got & lanes[1].got;
endmodule

// File: rtl/msglen_chk.sv
module msglen_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        enable,
  input logic        sop,
  input logic        byte_vld,
  input logic [15:0] msg_len,
  input logic        lsb_done,
  input logic        msb_done,
  input logic        done
);
  // R2: low flag only rises after an accepted, enabled byte
  assert_lsb_source_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lsb_done) |-> $past(byte_vld && enable));

  // R3: high byte never held without the low byte
  assert_msb_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(msb_done) |-> lsb_done);

  // R6: completed length frozen until a new message starts
  assert_len_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !sop) |=> ($stable(msg_len) && done));

  // R7: a start pulse leaves the high byte uncaptured
  assert_sop_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sop |=> !msb_done);

  // R8: disabled mode freezes captured state
  assert_disabled_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable && !sop) |=> ($stable(msg_len) && $stable(lsb_done) && $stable(msb_done)));
endmodule

bind msg_len_extract msglen_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .enable   (enable),
  .sop      (sop),
  .byte_vld (byte_vld),
  .msg_len  (msg_len),
  .lsb_done (lsb_done),
  .msb_done (msb_done),
  .done     (done)
);

// File: tb/sim_msg_len_extract.sv
`timescale 1ns/1ps
module sim_msg_len_extract;
  localparam int OFS_W = 11;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             enable, sop, pkt_end, byte_vld;
  logic [7:0]       byte_data;
  logic [OFS_W-1:0] len_ofs;
  logic [15:0]      msg_len;
  logic [31:0]      desc_len_word;
  logic             lsb_done, msb_done, done;

  int vectors = 0;
  int errors  = 0;

  // reference model state
  int   m_pos;
  bit   m_lf, m_hf;
  byte unsigned m_lo, m_hi;

  always #5 clk = ~clk;

  msg_len_extract #(.OFS_W(OFS_W)) u0 (
    .clk(clk), .rst_n(rst_n), .enable(enable), .sop(sop), .pkt_end(pkt_end),
    .byte_vld(byte_vld), .byte_data(byte_data), .len_ofs(len_ofs),
    .msg_len(msg_len), .desc_len_word(desc_len_word),
    .lsb_done(lsb_done), .msb_done(msb_done), .done(done)
  );

  task automatic compare(input string tag);
    logic [15:0] e_len;
    logic [31:0] e_word;
    e_len  = {m_hi, m_lo};
    e_word = {m_hi, m_lo, 16'h0000};
    vectors++;
    if (msg_len !== e_len || desc_len_word !== e_word || lsb_done !== m_lf ||
        msb_done !== m_hf || done !== (m_lf && m_hf)) begin
      errors++;
      $display("FAIL %s: len=%h word=%h lsb=%b msb=%b done=%b expected len=%h word=%h lsb=%b msb=%b done=%b",
               tag, msg_len, desc_len_word, lsb_done, msb_done, done,
               e_len, e_word, m_lf, m_hf, m_lf && m_hf);
    end
  endtask

  task automatic model_step();
    int p;
    p = sop ? 0 : m_pos;
    if (sop) begin m_lf = 0; m_hf = 0; m_lo = 0; m_hi = 0; end
    if (byte_vld && enable) begin
      if (!m_hf && m_lf && p == int'(len_ofs) + 1) begin m_hi = byte_data; m_hf = 1; end
      else if (!m_lf && p == int'(len_ofs)) begin m_lo = byte_data; m_lf = 1; end
    end
    if (byte_vld) m_pos = p + 1;
    else if (sop) m_pos = 0;
  endtask

  task automatic cyc(input bit v, input byte unsigned d, input bit s,
                     input bit pe, input bit en, input string tag);
    byte_vld = v; byte_data = d; sop = s; pkt_end = pe; enable = en;
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare(tag);
  endtask

  task automatic idle(input int n, input bit en, input string tag);
    for (int i = 0; i < n; i++) cyc(0, 8'h00, 0, 0, en, tag);
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: run hung, actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    rst_n = 0; enable = 0; sop = 0; pkt_end = 0; byte_vld = 0;
    byte_data = 0; len_ofs = 0;
    m_pos = 0; m_lf = 0; m_hf = 0; m_lo = 0; m_hi = 0;
    #23;
    compare("R1 in reset");
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    compare("R1 after release");

    // R2 R3 R5: offset 3, length straddles a packet boundary at position 3/4
    len_ofs = 3;
    cyc(0, 8'h00, 1, 0, 1, "R7 sop");
    for (int i = 0; i < 8; i++)
      cyc(1, 8'h10 + 8'(i), 0, (i == 3), 1, "R2 R3 R5 stream");
    // R6: more bytes after completion
    for (int i = 0; i < 4; i++) cyc(1, 8'hE0 + 8'(i), 0, 0, 1, "R6 post-done");

    // R4: byte with sop, offset 0
    len_ofs = 0;
    cyc(1, 8'hA5, 1, 0, 1, "R4 byte with sop");
    cyc(1, 8'h5A, 0, 0, 1, "R4 high byte");
    cyc(1, 8'hFF, 0, 1, 1, "R6 frozen");

    // R10 R5: gaps and boundary markers, offset 5
    len_ofs = 5;
    cyc(0, 8'h00, 1, 0, 1, "R7 sop clears");
    for (int i = 0; i < 8; i++) begin
      cyc(1, 8'h30 + 8'(i), 0, (i == 4), 1, "R10 R5 gapped stream");
      idle(i % 3, 1, "R10 gap");
    end

    // R8: enable low over the low-byte position
    len_ofs = 2;
    cyc(0, 8'h00, 1, 0, 1, "R7 sop");
    cyc(1, 8'h40, 0, 0, 1, "R8 pos0");
    cyc(1, 8'h41, 0, 0, 1, "R8 pos1");
    cyc(1, 8'h42, 0, 0, 0, "R8 disabled low pos");
    cyc(1, 8'h43, 0, 0, 1, "R8 R3 high without low");
    cyc(1, 8'h44, 0, 0, 1, "R8 after");
    // R8: disabled after low capture holds state
    cyc(0, 8'h00, 1, 0, 1, "R7 sop");
    cyc(1, 8'h50, 0, 0, 1, "R8 pos0");
    cyc(1, 8'h51, 0, 0, 1, "R8 pos1");
    cyc(1, 8'h52, 0, 0, 1, "R8 low captured");
    cyc(1, 8'h53, 0, 0, 0, "R8 disabled high pos");
    cyc(1, 8'h54, 0, 0, 1, "R8 R9 partial");

    // R9: message ends after low byte only
    len_ofs = 10;
    cyc(0, 8'h00, 1, 0, 1, "R7 sop");
    for (int i = 0; i < 11; i++)
      cyc(1, 8'h60 + 8'(i), 0, (i == 7), 1, "R9 short message");
    idle(6, 1, "R9 partial held");
    cyc(0, 8'h00, 1, 0, 1, "R7 clear partial");
    idle(2, 1, "R7 cleared");

    // R7: sop mid-capture restarts position
    len_ofs = 1;
    cyc(0, 8'h00, 1, 0, 1, "R7 sop");
    cyc(1, 8'h70, 0, 0, 1, "R7 pos0");
    cyc(1, 8'h71, 0, 0, 1, "R2 low");
    cyc(1, 8'h72, 1, 0, 1, "R7 sop with byte");
    cyc(1, 8'h73, 0, 0, 1, "R7 R2 recapture low");
    cyc(1, 8'h74, 0, 0, 1, "R3 high");
    idle(2, 1, "R6 hold");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule